// File: doc/BRIEF.md
# Byte-Serial Decoder for a Small 64-bit x86 Instruction Subset

This block takes x86-64 machine code one byte at a time over a valid/ready interface and, for each complete instruction, raises a one-cycle done pulse. The pulse carries the decoded record: the operation, the operand size, the destination and source register numbers, whether the destination is a memory operand, the sign-extended displacement, the immediate, and the number of bytes the instruction used.

The length is not known in advance. The decoder builds it as bytes arrive:
- any number of REX prefixes (upper nibble 0x4);
- a one-byte opcode;
- a ModR/M byte for the opcodes that have one;
- a displacement whose size comes from the mod field;
- an immediate whose size comes from the opcode.

The supported opcodes are:
- add and move from a register to a register or memory operand;
- move of a 32-bit immediate;
- subtract of a sign-extended 8-bit immediate;
- the single-byte register push.

Any other encoding ends the instruction with an unsupported flag. An instruction that would run past 15 bytes ends with an over-length flag. In both cases the next byte is taken as the start of a new instruction.

A front end that streams code bytes uses the block to find instruction boundaries and operand fields before any execution logic runs.

Top module: `insn_stream_decoder`

## Requirements
- R1: After reset, `dec_done` is 0 and `byte_ready` is 1.
- R2: Opcodes 0x01 (add) and 0x89 (move) each take a ModR/M byte. Its bits 7:6 are mod, bits 5:3 are reg and bits 2:0 are rm. The source is reg and the destination is rm. For mod = 11, `dec_mem` is 0 and `dec_disp` is 0. The `dec_op` encoding is 0 add, 1 sub, 2 move, 3 push.
- R3: A byte 0x40–0x4F before the opcode is a prefix and counts toward the length. Its bit 3 makes `dec_wide` 1 (64-bit); without it `dec_wide` is 0. Its bit 2 becomes bit 3 of `dec_src` for ModR/M forms. Its bit 0 becomes bit 3 of `dec_dst`, or of the push register. When several prefixes appear, the last one counts, and prefix state never carries into the next instruction.
- R4: mod = 00 with any rm other than 100 or 101 is a memory operand based on rm, with zero displacement. mod = 01 takes one displacement byte, sign-extended to 32 bits. In both cases `dec_mem` is 1 and `dec_dst` holds the base register.
- R5: mod = 10 takes four displacement bytes, least significant first.
- R6: Opcode 0xC7 with reg = 0 is a move of a four-byte immediate, least significant byte first. Opcode 0x83 with reg = 5 is a subtract of one immediate byte, sign-extended to 32 bits. In both cases the immediate follows any displacement and `dec_src` is 0.
- R7: Opcodes 0x50–0x57 are a push of the register in the opcode's low three bits. The push is one byte with no ModR/M, and it reports `dec_wide` = 1 and `dec_mem` = 0.
- R8: Each of the following ends the instruction at that byte with `dec_unsup` = 1 and `dec_len` equal to the bytes taken so far:
  - any opcode not listed above;
  - rm = 100 with mod ≠ 11;
  - mod = 00 with rm = 101;
  - 0xC7 with reg ≠ 0;
  - 0x83 with reg ≠ 5.
  The following byte starts a fresh instruction.
- R9: An instruction of exactly 15 bytes decodes normally. If the 15th byte does not complete the instruction, the block reports `dec_overlong` = 1 with `dec_len` = 15, and the next byte starts a fresh instruction.
- R10: `dec_done` rises in the cycle after the edge that accepts an instruction's last byte and lasts one cycle. `byte_ready` is 0 exactly in that cycle. Cycles with `byte_valid` low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | A code byte is offered |
| byte_data | input | 8 | The offered code byte |
| byte_ready | output | 1 | The block accepts a byte this cycle |
| dec_done | output | 1 | One-cycle pulse: the record below is valid |
| dec_op | output | 2 | 0 add, 1 sub, 2 move, 3 push |
| dec_wide | output | 1 | 1 for 64-bit operand size |
| dec_unsup | output | 1 | Unsupported encoding ended the instruction |
| dec_overlong | output | 1 | 15-byte limit exceeded |
| dec_dst | output | 4 | Destination register, or base register when dec_mem |
| dec_src | output | 4 | Source register (push register for push) |
| dec_mem | output | 1 | Destination is memory at dec_dst + dec_disp |
| dec_disp | output | 32 | Sign-extended displacement |
| dec_imm | output | 32 | Immediate, sign-extended when one byte |
| dec_len | output | 4 | Bytes used by the instruction |

## Verification
The properties expect reset to be held low for at least one edge before any byte is offered. They make no assumption about the byte values. They do assume that the output record is read only while `dec_done` is high, since between pulses the fields hold partial state. The stimulus offers bytes only at falling edges and holds each byte until the edge that accepts it. It sometimes leaves gaps with `byte_valid` low and keeps offering during the done cycle, so the stall path is exercised.

// File: rtl/insn_stream_decoder.sv
module insn_stream_decoder #(
  parameter int MAX_LEN = 15,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  output logic          byte_ready,
  output logic          dec_done,
  output logic [1:0]    dec_op,
  output logic          dec_wide,
  output logic          dec_unsup,
  output logic          dec_overlong,
  output logic [3:0]    dec_dst,
  output logic [3:0]    dec_src,
  output logic          dec_mem,
  output logic [31:0]   dec_disp,
  output logic [31:0]   dec_imm,
  output logic [LW-1:0] dec_len
);
  typedef enum logic [2:0] {S_OP, S_MODRM, S_DISP, S_IMM, S_DONE} st_t;
  localparam logic [1:0] OP_ADD = 2'd0, OP_SUB = 2'd1, OP_MOV = 2'd2, OP_PUSH = 2'd3;

  st_t st;
  logic [LW-1:0] cnt;
  logic rw, rr, rb;
  logic [7:0] opc;
  logic [2:0] dlen, ilen;
  logic [1:0] k;

  logic          acc, fin, over;
  logic [LW-1:0] cnt_n;
  logic          is_rex, is_push, known;
  logic [1:0]    md;
  logic [2:0]    rg, rmf;
  logic          mr_bad;
  logic [2:0]    mr_dlen, mr_ilen;
  logic          k_last_d, k_last_i;

  assign byte_ready = (st != S_DONE);
  assign dec_done   = (st == S_DONE);
  assign dec_len    = cnt;
  assign acc        = byte_valid && byte_ready;
  assign cnt_n      = cnt + LW'(1);

  assign is_rex  = byte_data[7:4] == 4'h4;
  assign is_push = byte_data[7:3] == 5'b01010;
  assign known   = (byte_data == 8'h01) || (byte_data == 8'h89) ||
                   (byte_data == 8'hC7) || (byte_data == 8'h83);

  assign md  = byte_data[7:6];
  assign rg  = byte_data[5:3];
  assign rmf = byte_data[2:0];
  assign mr_bad = (rmf == 3'd4 && md != 2'b11) || (md == 2'b00 && rmf == 3'd5) ||
                  (opc == 8'hC7 && rg != 3'd0) || (opc == 8'h83 && rg != 3'd5);
  assign mr_dlen = (md == 2'b01) ? 3'd1 : (md == 2'b10) ? 3'd4 : 3'd0;
  assign mr_ilen = (opc == 8'hC7) ? 3'd4 : (opc == 8'h83) ? 3'd1 : 3'd0;
  assign k_last_d = {1'b0, k} == 3'(dlen - 3'd1);
  assign k_last_i = {1'b0, k} == 3'(ilen - 3'd1);

  always_comb begin
    case (st)
      S_OP:    fin = is_push || !(is_rex || known);
      S_MODRM: fin = mr_bad || (mr_dlen == 3'd0 && mr_ilen == 3'd0);
      S_DISP:  fin = k_last_d && (ilen == 3'd0);
      S_IMM:   fin = k_last_i;
      default: fin = 1'b1;
    endcase
  end
  assign over = (cnt_n == LW'(MAX_LEN)) && !fin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_OP;
      cnt <= '0;
      {rw, rr, rb} <= 3'b000;
      opc <= 8'h00;
      dlen <= 3'd0;
      ilen <= 3'd0;
      k <= 2'd0;
      dec_op <= OP_ADD;
      dec_wide <= 1'b0;
      dec_unsup <= 1'b0;
      dec_overlong <= 1'b0;
      dec_dst <= 4'd0;
      dec_src <= 4'd0;
      dec_mem <= 1'b0;
      dec_disp <= 32'd0;
      dec_imm <= 32'd0;
    end else if (st == S_DONE) begin
      st <= S_OP;
      cnt <= '0;
      {rw, rr, rb} <= 3'b000;
    end else if (acc) begin
      cnt <= cnt_n;
      if (st == S_OP && cnt == '0) begin
        dec_op <= OP_ADD;
        dec_wide <= 1'b0;
        dec_unsup <= 1'b0;
        dec_overlong <= 1'b0;
        dec_dst <= 4'd0;
        dec_src <= 4'd0;
        dec_mem <= 1'b0;
        dec_disp <= 32'd0;
        dec_imm <= 32'd0;
      end
      if (over) begin
        dec_overlong <= 1'b1;
        st <= S_DONE;
      end else begin
        case (st)
          S_OP: begin
            if (is_rex) begin
              {rw, rr, rb} <= {byte_data[3], byte_data[2], byte_data[0]};
            end else if (is_push) begin
              dec_op <= OP_PUSH;
              dec_wide <= 1'b1;
              dec_src <= {rb, byte_data[2:0]};
              st <= S_DONE;
            end else if (known) begin
              opc <= byte_data;
              dec_wide <= rw;
              st <= S_MODRM;
            end else begin
              dec_unsup <= 1'b1;
              st <= S_DONE;
            end
          end
          S_MODRM: begin
            if (mr_bad) begin
              dec_unsup <= 1'b1;
              st <= S_DONE;
            end else begin
              dec_op  <= (opc == 8'h01) ? OP_ADD : (opc == 8'h83) ? OP_SUB : OP_MOV;
              dec_dst <= {rb, rmf};
              dec_src <= (opc == 8'h01 || opc == 8'h89) ? {rr, rg} : 4'd0;
              dec_mem <= (md != 2'b11);
              dlen <= mr_dlen;
              ilen <= mr_ilen;
              k <= 2'd0;
              st <= (mr_dlen != 3'd0) ? S_DISP : (mr_ilen != 3'd0) ? S_IMM : S_DONE;
            end
          end
          S_DISP: begin
            if (k == 2'd0) dec_disp <= {{24{byte_data[7]}}, byte_data};
            else dec_disp[{k, 3'b000} +: 8] <= byte_data;
            if (k_last_d) begin
              k <= 2'd0;
              st <= (ilen != 3'd0) ? S_IMM : S_DONE;
            end else begin
              k <= k + 2'd1;
            end
          end
          S_IMM: begin
            if (k == 2'd0) dec_imm <= {{24{byte_data[7]}}, byte_data};
            else dec_imm[{k, 3'b000} +: 8] <= byte_data;
            if (k_last_i) begin
              k <= 2'd0;
              st <= S_DONE;
            end else begin
              k <= k + 2'd1;
            end
          end
          default: st <= S_OP;
        endcase
      end
    end
  end
endmodule

// File: rtl/decoder_checks.sv
module decoder_checks #(
  parameter int MAX_LEN = 15,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_valid,
  input logic          byte_ready,
  input logic          dec_done,
  input logic [1:0]    dec_op,
  input logic          dec_wide,
  input logic          dec_unsup,
  input logic          dec_overlong,
  input logic          dec_mem,
  input logic [31:0]   dec_disp,
  input logic [31:0]   dec_imm,
  input logic [LW-1:0] dec_len
);
  logic ok;
  assign ok = dec_done && !dec_unsup && !dec_overlong;

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |=> !dec_done);
  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |-> !byte_ready);
  assert_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_done) |-> $past(byte_valid && byte_ready));
  assert_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |-> (dec_len != '0 && dec_len <= LW'(MAX_LEN)));
  assert_overlong_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_done && dec_overlong) |-> (dec_len == LW'(MAX_LEN) && !dec_unsup));
  assert_reg_nodisp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !dec_mem) |-> dec_disp == 32'd0);
  assert_imm8_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && dec_op == 2'd1) |-> (dec_imm[31:7] == '0 || dec_imm[31:7] == '1));
  assert_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && dec_op == 2'd3) |-> (dec_wide && !dec_mem && dec_imm == 32'd0));
endmodule

bind insn_stream_decoder decoder_checks u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_ready(byte_ready),
  .dec_done(dec_done), .dec_op(dec_op), .dec_wide(dec_wide), .dec_unsup(dec_unsup),
  .dec_overlong(dec_overlong), .dec_mem(dec_mem), .dec_disp(dec_disp),
  .dec_imm(dec_imm), .dec_len(dec_len)
);

// File: tb/insn_stream_decoder_bench.sv
module insn_stream_decoder_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic byte_ready, dec_done, dec_wide, dec_unsup, dec_overlong, dec_mem;
  logic [1:0] dec_op;
  logic [3:0] dec_dst, dec_src, dec_len;
  logic [31:0] dec_disp, dec_imm;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  insn_stream_decoder u_insn_stream_decoder (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .dec_done(dec_done), .dec_op(dec_op), .dec_wide(dec_wide),
    .dec_unsup(dec_unsup), .dec_overlong(dec_overlong), .dec_dst(dec_dst),
    .dec_src(dec_src), .dec_mem(dec_mem), .dec_disp(dec_disp), .dec_imm(dec_imm),
    .dec_len(dec_len)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    byte_valid = 1'b1;
    byte_data = b;
    while (!byte_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic feed(input logic [127:0] s, input int n);
    for (int i = 0; i < n; i++) put(s[8*(n-1-i) +: 8]);
  endtask

  task automatic expect_ok(input string tag, input logic [1:0] op, input logic wide,
                           input logic [3:0] dst, input logic [3:0] src, input logic mem,
                           input logic [31:0] disp, input logic [31:0] imm, input logic [3:0] len);
    chk({tag, " done"}, 32'(dec_done), 32'd1);
    chk({tag, " unsup"}, 32'(dec_unsup), 32'd0);
    chk({tag, " overlong"}, 32'(dec_overlong), 32'd0);
    chk({tag, " op"}, 32'(dec_op), 32'(op));
    chk({tag, " wide"}, 32'(dec_wide), 32'(wide));
    chk({tag, " dst"}, 32'(dec_dst), 32'(dst));
    chk({tag, " src"}, 32'(dec_src), 32'(src));
    chk({tag, " mem"}, 32'(dec_mem), 32'(mem));
    chk({tag, " disp"}, dec_disp, disp);
    chk({tag, " imm"}, dec_imm, imm);
    chk({tag, " len"}, 32'(dec_len), 32'(len));
  endtask

  task automatic expect_bad(input string tag, input logic unsup, input logic ovl, input logic [3:0] len);
    chk({tag, " done"}, 32'(dec_done), 32'd1);
    chk({tag, " unsup"}, 32'(dec_unsup), 32'(unsup));
    chk({tag, " overlong"}, 32'(dec_overlong), 32'(ovl));
    chk({tag, " len"}, 32'(dec_len), 32'(len));
  endtask

  task automatic t_reset;
    chk("R1 done after reset", 32'(dec_done), 32'd0);
    chk("R1 ready after reset", 32'(byte_ready), 32'd1);
  endtask

  task automatic t_regform;
    feed(128'h89C6, 2);   expect_ok("R2 mov reg", 2'd2, 0, 4'd6, 4'd0, 0, 0, 0, 4'd2);
    feed(128'h01D0, 2);   expect_ok("R2 add reg", 2'd0, 0, 4'd0, 4'd2, 0, 0, 0, 4'd2);
  endtask

  task automatic t_rex;
    feed(128'h4889E5, 3);   expect_ok("R3 rex.w", 2'd2, 1, 4'd5, 4'd4, 0, 0, 0, 4'd3);
    feed(128'h4501DE, 3);   expect_ok("R3 rex.rb", 2'd0, 0, 4'd14, 4'd11, 0, 0, 0, 4'd3);
    feed(128'h404889C6, 4); expect_ok("R3 two prefixes w last", 2'd2, 1, 4'd6, 4'd0, 0, 0, 0, 4'd4);
    feed(128'h484089C6, 4); expect_ok("R3 last prefix wins", 2'd2, 0, 4'd6, 4'd0, 0, 0, 0, 4'd4);
    feed(128'h89C6, 2);     expect_ok("R3 no carry", 2'd2, 0, 4'd6, 4'd0, 0, 0, 0, 4'd2);
  endtask

  task automatic t_mem8;
    feed(128'h891A, 2);   expect_ok("R4 mod00", 2'd2, 0, 4'd2, 4'd3, 1, 0, 0, 4'd2);
    feed(128'h8945F8, 3); expect_ok("R4 disp8 neg", 2'd2, 0, 4'd5, 4'd0, 1, 32'hFFFFFFF8, 0, 4'd3);
    feed(128'h01437F, 3); expect_ok("R4 disp8 pos", 2'd0, 0, 4'd3, 4'd0, 1, 32'h7F, 0, 4'd3);
  endtask

  task automatic t_mem32;
    feed(128'h898378563412, 6);
    expect_ok("R5 disp32", 2'd2, 0, 4'd3, 4'd0, 1, 32'h12345678, 0, 4'd6);
    feed(128'h49C78000010080EFBEADDE, 11);
    expect_ok("R5 disp32 imm32", 2'd2, 1, 4'd8, 4'd0, 1, 32'h80000100, 32'hDEADBEEF, 4'd11);
  endtask

  task automatic t_imm;
    feed(128'hC745F02C050000, 7);
    expect_ok("R6 imm32 after disp8", 2'd2, 0, 4'd5, 4'd0, 1, 32'hFFFFFFF0, 32'h52C, 4'd7);
    feed(128'h4883EC10, 4); expect_ok("R6 sub imm8", 2'd1, 1, 4'd4, 4'd0, 0, 0, 32'h10, 4'd4);
    feed(128'h83E8F0, 3);   expect_ok("R6 sub imm8 neg", 2'd1, 0, 4'd0, 4'd0, 0, 0, 32'hFFFFFFF0, 4'd3);
    feed(128'h836DFC80, 4);
    expect_ok("R6 disp then imm", 2'd1, 0, 4'd5, 4'd0, 1, 32'hFFFFFFFC, 32'hFFFFFF80, 4'd4);
  endtask

  task automatic t_push;
    feed(128'h55, 1);   expect_ok("R7 push", 2'd3, 1, 4'd0, 4'd5, 0, 0, 0, 4'd1);
    feed(128'h4157, 2); expect_ok("R7 push rex.b", 2'd3, 1, 4'd0, 4'd15, 0, 0, 0, 4'd2);
  endtask

  task automatic t_unsup;
    feed(128'h0F, 1);     expect_bad("R8 other opcode", 1, 0, 4'd1);
    feed(128'h55, 1);     expect_ok("R8 resync", 2'd3, 1, 4'd0, 4'd5, 0, 0, 0, 4'd1);
    feed(128'h66, 1);     expect_bad("R8 legacy prefix", 1, 0, 4'd1);
    feed(128'h8904, 2);   expect_bad("R8 sib", 1, 0, 4'd2);
    feed(128'h418905, 3); expect_bad("R8 rip rel", 1, 0, 4'd3);
    feed(128'hC7C8, 2);   expect_bad("R8 c7 reg1", 1, 0, 4'd2);
    feed(128'h83C0, 2);   expect_bad("R8 83 reg0", 1, 0, 4'd2);
    feed(128'h01D0, 2);   expect_ok("R8 resync modrm", 2'd0, 0, 4'd0, 4'd2, 0, 0, 0, 4'd2);
  endtask

  task automatic t_overlong;
    feed({{13{8'h40}}, 16'h89C6}, 15);
    expect_ok("R9 exactly 15", 2'd2, 0, 4'd6, 4'd0, 0, 0, 0, 4'd15);
    feed({{14{8'h41}}, 8'h89}, 15); expect_bad("R9 opcode at 15", 0, 1, 4'd15);
    feed(128'hC6, 1);               expect_bad("R9 resync byte", 1, 0, 4'd1);
    feed({15{8'h41}}, 15);          expect_bad("R9 prefixes only", 0, 1, 4'd15);
    feed(128'h50, 1);               expect_ok("R9 prefix cleared", 2'd3, 1, 4'd0, 4'd0, 0, 0, 0, 4'd1);
  endtask

  task automatic t_handshake;
    logic [7:0] seq [4] = '{8'h48, 8'h83, 8'hEC, 8'h10};
    for (int i = 0; i < 4; i++) begin
      put(seq[i]);
      if (i < 3) begin
        for (int g = 0; g < 3; g++) begin
          chk("R10 no done in gap", 32'(dec_done), 32'd0);
          chk("R10 ready in gap", 32'(byte_ready), 32'd1);
          @(negedge clk);
        end
      end
    end
    expect_ok("R10 gapped", 2'd1, 1, 4'd4, 4'd0, 0, 0, 32'h10, 4'd4);
    chk("R10 ready low on done", 32'(byte_ready), 32'd0);
    @(negedge clk);
    chk("R10 done one cycle", 32'(dec_done), 32'd0);
    chk("R10 ready back", 32'(byte_ready), 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regform;
    t_rex;
    t_mem8;
    t_mem32;
    t_imm;
    t_push;
    t_unsup;
    t_overlong;
    t_handshake;
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule